// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

The block folds a wide set of level-sensitive interrupt lines into one line per group. Every group has eight sources and its own eight-bit enable mask. A group line is raised when at least one of its sources is both high and enabled. Software controls the masks through a small 32-bit register port. It can set mask bits by writing ones to one word and clear them by writing ones to another. It can also read each group's raw levels, read its enabled-and-high levels, and read a packed summary of which group lines are raised.

The registers are arranged in 16-byte blocks, one block for each run of four consecutive groups. Within every word of a block, each group owns one byte lane. The summary words follow the last block. Pending state is not stored: it is the present input level. Clearing an input therefore removes its contribution on the next clock.

A parameter can switch off the groups at and above a chosen count. This serves instances that drive only some of the output lines. Inputs that belong to the switched-off groups are ignored.

Top module: `irq_group_combiner`

## Requirements
- R1: Input n belongs to group n>>3 at bit n&7. Output grp_out[g] is high exactly when (enable mask of g) AND (input bits of g) is nonzero. It changes on the first clock edge after an input change, and on the same edge that registers an enable write.
- R2: Pending bits are the live input levels, with no latching. Reading word 2 of block q (byte address 16q+8) returns the input byte of group 4q+i in bits 8i+7..8i.
- R3: Reading word 3 of block q (address 16q+12) returns, in byte lane i, the enable mask of group 4q+i ANDed with its pending bits.
- R4: Writing word 0 of block q (address 16q) ORs byte lane i of the data into the mask of group 4q+i. Zero data bits leave mask bits unchanged.
- R5: Writing word 1 of block q (address 16q+4) clears every mask bit of group 4q+i where byte lane i of the data is one. Other mask bits are unchanged.
- R6: Reads of word 0 or word 1 of any block return zero.
- R7: Reading address 0x100 returns grp_out[31:0]. Reading address 0x104 returns grp_out[63:32]. Both values are sampled in the request cycle.
- R8: A read request gives rsp_valid high on the next cycle, with its data in rsp_rdata. Reads at 0x108 and above return zero.
- R9: Writes to words 2 or 3 of any block, to the summary words, or at 0x108 and above change no mask. Each such write raises err_pulse for exactly one cycle, on the next cycle. Writes to words 0 and 1 never raise err_pulse.
- R10: While rst_n is low at a clock edge, every mask, grp_out, err_pulse and rsp_valid clears.
- R11: For a group index at or above ACTIVE_GROUPS, inputs are ignored. Its raw status reads zero and its output stays low whatever its mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 512 | Level interrupt sources, eight per group |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle flag for an illegal write |
| grp_out | output | 64 | One combined interrupt line per group |

## Verification
The bench aims at the lane arithmetic. A design with an off-by-one block or lane decode enables the wrong group, and the bench sees that output stay low while a neighbour rises. It checks that a deasserted input drops its group line on the next cycle, which catches any design that latches pending state. It drives inputs into the switched-off groups with their masks fully set, which exposes a design that forwards them. It writes to status, summary and out-of-range addresses and then reads the masks back through the masked-status word. A design that decoded those writes as enable updates would show changed masks, and one that skipped the flag would leave err_pulse low.

// File: rtl/irqc_pkg.sv
// Shared definitions for the grouped interrupt combiner.
// Assumes byte-addressed 32-bit words and 16-byte register blocks.
package irqc_pkg;
    // Word codes inside one register block (address bits [3:2]).
    localparam logic [1:0] WS_SET    = 2'd0;
    localparam logic [1:0] WS_CLR    = 2'd1;
    localparam logic [1:0] WS_RAW    = 2'd2;
    localparam logic [1:0] WS_MASKED = 2'd3;

    // Source selected for read data.
    typedef enum logic [1:0] {
        RK_ZERO   = 2'd0,
        RK_RAW    = 2'd1,
        RK_MASKED = 2'd2,
        RK_SUM    = 2'd3
    } rd_kind_e;
endpackage

// File: rtl/irqc_reg_decode.sv
// Address decode for the combiner register port.
// Produces enable-write strobes, the read selection and a registered
// error pulse for writes outside the two writable words of a block.
// Assumes one request per cycle and no back-pressure.
module irqc_reg_decode
    import irqc_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_BLKS   = 16,
    parameter int SUM_WORDS  = 2,
    localparam int BLK_W     = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
    localparam int SUM_IDX_W = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 set_we,
    output logic                 clr_we,
    output logic [BLK_W-1:0]     blk_sel,
    output logic                 rd_en,
    output rd_kind_e             rd_kind,
    output logic [SUM_IDX_W-1:0] sum_idx,
    output logic                 err_pulse
);
    localparam int SUM_BASE   = NUM_BLKS * 16;
    localparam int REGION_END = SUM_BASE + 4 * SUM_WORDS;

    logic [ADDR_W-5:0] blk_field;
    logic [1:0]        word_sel;
    logic              in_blk;
    logic              in_sum;
    logic              illegal_wr;
    logic              err_q;

    // Split the address into block and word fields and classify it.
    always_comb begin
        blk_field = req_addr[ADDR_W-1:4];
        word_sel  = req_addr[3:2];
        in_blk    = (int'(blk_field) < NUM_BLKS);
        in_sum    = (req_addr >= ADDR_W'(SUM_BASE)) && (req_addr < ADDR_W'(REGION_END));
        blk_sel   = blk_field[BLK_W-1:0];
        sum_idx   = SUM_IDX_W'((req_addr - ADDR_W'(SUM_BASE)) >> 2);
    end

    // Write strobes and illegal-write detection.
    always_comb begin
        set_we     = req_valid && req_write && in_blk && (word_sel == WS_SET);
        clr_we     = req_valid && req_write && in_blk && (word_sel == WS_CLR);
        illegal_wr = req_valid && req_write && !(set_we || clr_we);
    end

    // Read source selection.
    always_comb begin
        rd_en   = req_valid && !req_write;
        rd_kind = RK_ZERO;
        if (in_blk) begin
            if (word_sel == WS_RAW)         rd_kind = RK_RAW;
            else if (word_sel == WS_MASKED) rd_kind = RK_MASKED;
        end else if (in_sum) begin
            rd_kind = RK_SUM;
        end
    end

    // Register the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= illegal_wr;
    end

    assign err_pulse = err_q;
endmodule

// File: rtl/irqc_mask_bank.sv
// Per-group enable masks with write-one-to-set and write-one-to-clear.
// Group g sits in block g/BLK_GROUPS, byte lane g%BLK_GROUPS.
// mask_d is the next-state value, so consumers can react on the same edge.
module irqc_mask_bank #(
    parameter int NUM_GROUPS = 64,
    parameter int SRC_W      = 8,
    parameter int DATA_W     = 32,
    localparam int BLK_GROUPS = DATA_W / SRC_W,
    localparam int NUM_BLKS   = NUM_GROUPS / BLK_GROUPS,
    localparam int BLK_W      = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_we,
    input  logic                        clr_we,
    input  logic [BLK_W-1:0]            blk_sel,
    input  logic [DATA_W-1:0]           wdata,
    output logic [NUM_GROUPS*SRC_W-1:0] mask_q,
    output logic [NUM_GROUPS*SRC_W-1:0] mask_d
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int BLK  = g / BLK_GROUPS;
        localparam int LANE = g % BLK_GROUPS;
        logic hit;
        logic [SRC_W-1:0] lane_data;

        // Next mask for this group from set or clear writes.
        always_comb begin
            hit       = (blk_sel == BLK_W'(BLK));
            lane_data = wdata[LANE*SRC_W +: SRC_W];
            mask_d[g*SRC_W +: SRC_W] = mask_q[g*SRC_W +: SRC_W];
            if (set_we && hit)
                mask_d[g*SRC_W +: SRC_W] = mask_q[g*SRC_W +: SRC_W] | lane_data;
            else if (clr_we && hit)
                mask_d[g*SRC_W +: SRC_W] = mask_q[g*SRC_W +: SRC_W] & ~lane_data;
        end

        // Hold the mask for this group.
        always_ff @(posedge clk) begin
            if (!rst_n) mask_q[g*SRC_W +: SRC_W] <= '0;
            else        mask_q[g*SRC_W +: SRC_W] <= mask_d[g*SRC_W +: SRC_W];
        end
    end
endmodule

// File: rtl/irqc_group_eval.sv
// Gates source levels into pending bits and forms the registered group lines.
// Groups at or above ACTIVE_GROUPS see all-zero pending bits.
// Assumes irq_in is synchronous to clk.
module irqc_group_eval #(
    parameter int NUM_GROUPS    = 64,
    parameter int SRC_W         = 8,
    parameter int ACTIVE_GROUPS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*SRC_W-1:0] irq_in,
    input  logic [NUM_GROUPS*SRC_W-1:0] mask_d,
    output logic [NUM_GROUPS*SRC_W-1:0] pend,
    output logic [NUM_GROUPS-1:0]       grp_out
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        if (g < ACTIVE_GROUPS) begin : g_live
            // Pending follows the live level.
            assign pend[g*SRC_W +: SRC_W] = irq_in[g*SRC_W +: SRC_W];
        end else begin : g_off
            // Switched-off group: sources ignored.
            assign pend[g*SRC_W +: SRC_W] = '0;
        end

        // Register the combined line for this group.
        always_ff @(posedge clk) begin
            if (!rst_n) grp_out[g] <= 1'b0;
            else        grp_out[g] <= |(mask_d[g*SRC_W +: SRC_W] & pend[g*SRC_W +: SRC_W]);
        end
    end
endmodule

// File: rtl/irqc_read_port.sv
// Read data path: selects raw, masked, summary or zero data and registers it.
// Assumes the summary word count times DATA_W equals NUM_GROUPS.
module irqc_read_port
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter int SRC_W      = 8,
    parameter int DATA_W     = 32,
    localparam int BLK_GROUPS = DATA_W / SRC_W,
    localparam int NUM_BLKS   = NUM_GROUPS / BLK_GROUPS,
    localparam int BLK_W      = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
    localparam int SUM_WORDS  = NUM_GROUPS / DATA_W,
    localparam int SUM_IDX_W  = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  rd_kind_e                    rd_kind,
    input  logic [BLK_W-1:0]            blk_sel,
    input  logic [SUM_IDX_W-1:0]        sum_idx,
    input  logic [NUM_GROUPS*SRC_W-1:0] mask_q,
    input  logic [NUM_GROUPS*SRC_W-1:0] pend,
    input  logic [NUM_GROUPS-1:0]       grp_out,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata
);
    logic [DATA_W-1:0] raw_word;
    logic [DATA_W-1:0] msk_word;
    logic [DATA_W-1:0] rd_next;

    for (genvar i = 0; i < BLK_GROUPS; i++) begin : g_lane
        // Gather lane i of the selected block.
        always_comb begin
            raw_word[i*SRC_W +: SRC_W] = pend[(int'(blk_sel)*BLK_GROUPS + i)*SRC_W +: SRC_W];
            msk_word[i*SRC_W +: SRC_W] = pend[(int'(blk_sel)*BLK_GROUPS + i)*SRC_W +: SRC_W]
                                       & mask_q[(int'(blk_sel)*BLK_GROUPS + i)*SRC_W +: SRC_W];
        end
    end

    // Choose the read source.
    always_comb begin
        unique case (rd_kind)
            RK_RAW:    rd_next = raw_word;
            RK_MASKED: rd_next = msk_word;
            RK_SUM:    rd_next = grp_out[int'(sum_idx)*DATA_W +: DATA_W];
            default:   rd_next = '0;
        endcase
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_next : '0;
        end
    end
endmodule

// File: rtl/irq_group_combiner.sv
// Grouped level interrupt combiner, top level.
// Eight-source groups, each with an enable mask and one registered output.
// Four groups share each 16-byte register block, and a packed summary of
// the group lines follows the last block. Synchronous active-low reset.
module irq_group_combiner
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS    = 64,
    parameter int SRC_W         = 8,
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 12,
    parameter int ACTIVE_GROUPS = 64,
    localparam int NUM_SRC      = NUM_GROUPS * SRC_W,
    localparam int BLK_GROUPS   = DATA_W / SRC_W,
    localparam int NUM_BLKS     = NUM_GROUPS / BLK_GROUPS,
    localparam int BLK_W        = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
    localparam int SUM_WORDS    = NUM_GROUPS / DATA_W,
    localparam int SUM_IDX_W    = (SUM_WORDS > 1) ? $clog2(SUM_WORDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    irq_in,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  err_pulse,
    output logic [NUM_GROUPS-1:0] grp_out
);
    logic                 set_we;
    logic                 clr_we;
    logic [BLK_W-1:0]     blk_sel;
    logic                 rd_en;
    rd_kind_e             rd_kind;
    logic [SUM_IDX_W-1:0] sum_idx;
    logic [NUM_SRC-1:0]   mask_q;
    logic [NUM_SRC-1:0]   mask_d;
    logic [NUM_SRC-1:0]   pend;

    irqc_reg_decode #(
        .ADDR_W(ADDR_W), .NUM_BLKS(NUM_BLKS), .SUM_WORDS(SUM_WORDS)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .set_we(set_we), .clr_we(clr_we), .blk_sel(blk_sel),
        .rd_en(rd_en), .rd_kind(rd_kind), .sum_idx(sum_idx),
        .err_pulse(err_pulse)
    );

    irqc_mask_bank #(
        .NUM_GROUPS(NUM_GROUPS), .SRC_W(SRC_W), .DATA_W(DATA_W)
    ) u_mask (
        .clk(clk), .rst_n(rst_n),
        .set_we(set_we), .clr_we(clr_we), .blk_sel(blk_sel),
        .wdata(req_wdata), .mask_q(mask_q), .mask_d(mask_d)
    );

    irqc_group_eval #(
        .NUM_GROUPS(NUM_GROUPS), .SRC_W(SRC_W), .ACTIVE_GROUPS(ACTIVE_GROUPS)
    ) u_eval (
        .clk(clk), .rst_n(rst_n),
        .irq_in(irq_in), .mask_d(mask_d), .pend(pend), .grp_out(grp_out)
    );

    irqc_read_port #(
        .NUM_GROUPS(NUM_GROUPS), .SRC_W(SRC_W), .DATA_W(DATA_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_kind(rd_kind), .blk_sel(blk_sel), .sum_idx(sum_idx),
        .mask_q(mask_q), .pend(pend), .grp_out(grp_out),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/irqc_checker.sv
// Protocol and state checks for the combiner, bound to the top module.
// Assumes the summary base follows the last 16-byte block.
module irqc_checker #(
    parameter int NUM_GROUPS = 64,
    parameter int SRC_W      = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int SUM_BASE   = 256
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [ADDR_W-1:0]           req_addr,
    input logic                        rsp_valid,
    input logic [DATA_W-1:0]           rsp_rdata,
    input logic                        err_pulse,
    input logic [NUM_GROUPS-1:0]       grp_out,
    input logic [NUM_GROUPS*SRC_W-1:0] mask_q
);
    logic blk_acc;
    assign blk_acc = (req_addr < ADDR_W'(SUM_BASE));

    // R9: status-word writes inside a block flag an error.
    assert_status_write_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && blk_acc && req_addr[3]) |=> err_pulse);

    // R9: enable-word writes never flag.
    assert_enable_write_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && blk_acc && !req_addr[3]) |=> !err_pulse);

    // R4: masks hold without a write.
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(mask_q));

    // R6: enable words read as zero.
    assert_enable_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && blk_acc && !req_addr[3]) |=> (rsp_rdata == '0));

    // R8: response strobe one cycle after a read.
    assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R8: no response without a read.
    assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R7: first summary word mirrors the low group lines.
    assert_summary_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(SUM_BASE))
        |=> (rsp_rdata == $past(grp_out[DATA_W-1:0])));

    // R10: all lines low on leaving reset.
    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (grp_out == '0 && !err_pulse && !rsp_valid));
endmodule

bind irq_group_combiner irqc_checker #(
    .NUM_GROUPS(NUM_GROUPS), .SRC_W(SRC_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .SUM_BASE(NUM_BLKS * 16)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_pulse(err_pulse), .grp_out(grp_out), .mask_q(mask_q)
);

// File: tb/sim_irq_group_combiner.sv
// Self-checking bench: directed corner cases plus seeded random operations.
module sim_irq_group_combiner;
    localparam int NG  = 64;
    localparam int ACT = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [511:0]  irq = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          err_pulse;
    logic [63:0]   grp_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [7:0] m_mask [NG];

    always #2.5 clk = ~clk;

    irq_group_combiner #(.ACTIVE_GROUPS(ACT)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .err_pulse(err_pulse), .grp_out(grp_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_pend(input int g);
        return (g < ACT) ? irq[g*8 +: 8] : 8'h00;
    endfunction

    function automatic logic [63:0] m_out();
        logic [63:0] v;
        for (int g = 0; g < NG; g++) v[g] = |(m_mask[g] & m_pend(g));
        return v;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        logic [31:0] v = '0;
        logic [63:0] o = m_out();
        if (a < 12'h100) begin
            for (int i = 0; i < 4; i++) begin
                int g = int'(a[7:4]) * 4 + i;
                if (a[3:2] == 2'd2) v[i*8 +: 8] = m_pend(g);
                if (a[3:2] == 2'd3) v[i*8 +: 8] = m_pend(g) & m_mask[g];
            end
        end else if (a >= 12'h100 && a < 12'h104) v = o[31:0];
        else if (a >= 12'h104 && a < 12'h108) v = o[63:32];
        return v;
    endfunction

    task automatic check_out(input string tag);
        chk(grp_out === m_out(), tag, grp_out, m_out());
    endtask

    // Change inputs at a falling edge, check lines one edge later (R1, R2).
    task automatic set_irq(input logic [511:0] v);
        @(negedge clk);
        irq = v;
        @(negedge clk);
        check_out("R1 outputs after input change");
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        bit legal = (a < 12'h100) && (a[3] == 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        if (legal) begin
            for (int i = 0; i < 4; i++) begin
                int g = int'(a[7:4]) * 4 + i;
                if (a[2]) m_mask[g] = m_mask[g] & ~d[i*8 +: 8];
                else      m_mask[g] = m_mask[g] | d[i*8 +: 8];
            end
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(err_pulse === !legal, "R9 err flag after write", 64'(err_pulse), 64'(!legal));
        check_out(legal ? "R4 R5 outputs after enable write" : "R9 outputs after illegal write");
    endtask

    task automatic do_read(input logic [11:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        e = m_read(a);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R8 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_rdata === e, tag, 64'(rsp_rdata), 64'(e));
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int g = 0; g < NG; g++) m_mask[g] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(grp_out === '0, "R10 reset grp_out", grp_out, 64'd0);
        chk(err_pulse === 1'b0, "R10 reset err", 64'(err_pulse), 64'd0);
        chk(rsp_valid === 1'b0, "R10 reset rsp_valid", 64'(rsp_valid), 64'd0);

        // R1 R4: source 43 -> group 5 bit 3; group 5 is block 1 lane 1.
        set_irq(512'd1 << 43);
        chk(grp_out[5] === 1'b0, "R1 masked source stays low", 64'(grp_out[5]), 64'd0);
        do_write(12'h010, 32'h0000_0800);
        chk(grp_out === (64'd1 << 5), "R4 group 5 enabled", grp_out, 64'd1 << 5);
        do_read(12'h018, "R2 raw status block 1");
        do_read(12'h01C, "R3 masked status block 1");
        do_read(12'h010, "R6 set word reads zero");
        do_read(12'h014, "R6 clear word reads zero");
        // R2: deassert, no latching
        set_irq('0);
        chk(grp_out[5] === 1'b0, "R2 level drop clears output", 64'(grp_out[5]), 64'd0);
        // R5: clear only bit 3 of group 5
        do_write(12'h010, 32'h0000_0C00);
        do_write(12'h014, 32'h0000_0800);
        set_irq(512'd1 << 42);
        chk(grp_out[5] === 1'b1, "R5 uncleared bit still enabled", 64'(grp_out[5]), 64'd1);
        // R7: summary high word via group 33 (block 8 lane 1)
        do_write(12'h080, 32'hFFFF_FFFF);
        set_irq((512'd1 << 42) | (512'd1 << (33*8+7)));
        do_read(12'h104, "R7 summary high word");
        do_read(12'h100, "R7 summary low word");
        // R11: group 62 (block 15 lane 2) ignored
        do_write(12'h0F0, 32'hFFFF_FFFF);
        set_irq(512'hFF << (62*8));
        chk(grp_out[62] === 1'b0, "R11 ignored group output", 64'(grp_out[62]), 64'd0);
        do_read(12'h0F8, "R11 ignored group raw status");
        // R9: illegal writes and readback
        do_write(12'h0F8, 32'h0);
        do_write(12'h104, 32'hFFFF_FFFF);
        do_write(12'h108, 32'hFFFF_FFFF);
        do_write(12'h01C, 32'hFFFF_FFFF);
        set_irq({64{8'hFF}});
        do_read(12'h01C, "R9 masks unchanged by illegal writes");
        do_read(12'h108, "R8 past region reads zero");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(5, 0);
            case (op)
                0: set_irq({$urandom(), $urandom(), $urandom(), $urandom(),
                            $urandom(), $urandom(), $urandom(), $urandom(),
                            $urandom(), $urandom(), $urandom(), $urandom(),
                            $urandom(), $urandom(), $urandom(), $urandom()} &
                           {16{$urandom()}});
                1: do_write({4'h0, 4'($urandom_range(15, 0)), 4'h0}, $urandom() & $urandom());
                2: do_write({4'h0, 4'($urandom_range(15, 0)), 4'h4}, $urandom());
                3: do_read({4'h0, 4'($urandom_range(15, 0)), 2'($urandom_range(3, 0)), 2'b00},
                           "R2 R3 R6 random block read");
                4: do_read(12'h100 + 12'($urandom_range(3, 0) * 4), "R7 R8 random summary read");
                default: do_write(($urandom_range(1, 0) == 0) ?
                                  {4'h0, 4'($urandom_range(15, 0)), 1'b1, 1'($urandom_range(1, 0)), 2'b00} :
                                  12'($urandom_range(4095, 256)), $urandom());
            endcase
        end

        // R10: reset mid-run clears masks
        @(negedge clk);
        rst_n = 1'b0;
        for (int g = 0; g < NG; g++) m_mask[g] = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grp_out === '0, "R10 reset clears outputs", grp_out, 64'd0);
        do_read(12'h03C, "R10 masks cleared after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule